// File: doc/BRIEF.md
# Display RAM Write Address Sequencer

This block keeps the write pointer for a byte-organised display memory of 40 by 101 pixels. The memory is split into five horizontal bands (banks) of eight pixel lines each. Every byte holds one column's eight vertically stacked pixels within a band: band n covers display lines 8n to 8n+7, with the least significant bit on the topmost line of the band. The column index selects the column output of the same number directly. A command decoder loads a bank index, a column index and a stepping mode into the block. A write path pulses a strobe once per byte written. The block presents the current bank index, the current column index and the flat byte address on its outputs.

In the cycle a strobe is high, the outputs show the address the byte goes to. At the next clock edge the pointer moves by one position. With column-first stepping it runs along a band and then moves to the next band. With bank-first stepping it runs down a column through all five bands and then moves to the next column. In both modes the byte after the last position (bank 4, column 100) goes to the origin.

The strobe carries no ready signal. The sequencer accepts one strobe on every clock with no back-pressure, so an upstream valid pulse can drive the strobe directly. All control pins are plain level inputs that are sampled on the rising clock edge.

Top module: `dram_addr_seq`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets bank 0, column 0 and column-first mode (mode code 0). After reset with no mode load, one strobe advances the column to 1.
- R2: The bank output never leaves 0..4 and the column output never leaves 0..100.
- R3: flat_o equals bank_o × 101 + col_o as a 9-bit unsigned value, ranging from 0 to 504.
- R4: In mode 0 (column-first), a strobe with no index load adds one to the column. From column 100 it goes to column 0 of the next bank, so the flat address rises by one.
- R5: In mode 1 (bank-first), a strobe with no index load adds one to the bank and keeps the column. From bank 4 it goes to bank 0 of the next column.
- R6: In either mode, a strobe at bank 4, column 100 with no index load moves the pointer to bank 0, column 0.
- R7: An index load (bank_ld or col_ld) appears on the outputs after the next clock edge. When either load is high, the strobe in that cycle does not advance the pointer. A field that is not loaded keeps its value.
- R8: A bank load above 4 writes bank 0. A column load above 100 writes column 0. Values 4 and 100 are accepted as given.
- R9: A mode load (mode_ld, mode_in: 0 column-first, 1 bank-first) takes effect after the next clock edge. A strobe in the same cycle steps under the previous mode and is not blocked.
- R10: With no strobe and no index load, bank and column hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_ld | input | 1 | Load stepping mode from mode_in |
| mode_in | input | 1 | 0 column-first, 1 bank-first |
| bank_ld | input | 1 | Load bank index from bank_in |
| bank_in | input | 3 | Bank index to load |
| col_ld | input | 1 | Load column index from col_in |
| col_in | input | 7 | Column index to load |
| wr_stb | input | 1 | Byte-write strobe; advances the pointer |
| bank_o | output | 3 | Current bank index |
| col_o | output | 7 | Current column index |
| flat_o | output | 9 | Current flat byte address |

## Verification
Two functions can fall in the same cycle: an index load and a write strobe, or a mode load and a write strobe. The bench forces both cases on purpose. In the first it loads only the column during a strobe and checks that the loaded column appears while the bank does not move. In the second it loads bank-first mode during a strobe in column-first mode and checks that this strobe still advances the column, while the following strobe advances the bank. A long phase with random overlaps of all loads and strobes is then compared on every clock against a behavioural model that steps a flat integer address.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic {
    STEP_COL  = 1'b0,
    STEP_BANK = 1'b1
  } step_mode_e;
endpackage

// File: rtl/dram_idx_clamp.sv
module dram_idx_clamp #(
  parameter int W     = 3,
  parameter int LIMIT = 5
) (
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] idx_o
);
  localparam logic [W:0] LIM = (W+1)'(LIMIT);

  always_comb begin
    if ({1'b0, raw_i} < LIM) idx_o = raw_i;
    else                     idx_o = '0;
  end
endmodule

// File: rtl/dram_step_next.sv
module dram_step_next
  import dram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int NUM_COLS  = 101,
  parameter int BANK_W    = 3,
  parameter int COL_W     = 7
) (
  input  step_mode_e        mode_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col_o
);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);
  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(NUM_COLS - 1);

  logic bank_end, col_end;
  logic [BANK_W-1:0] bank_inc;
  logic [COL_W-1:0]  col_inc;

  assign bank_end = (bank_i == LAST_BANK);
  assign col_end  = (col_i == LAST_COL);
  assign bank_inc = bank_end ? '0 : bank_i + 1'b1;
  assign col_inc  = col_end  ? '0 : col_i + 1'b1;

  always_comb begin
    bank_o = bank_i;
    col_o  = col_i;
    if (mode_i == STEP_COL) begin
      col_o = col_inc;
      if (col_end) bank_o = bank_inc;
    end else begin
      bank_o = bank_inc;
      if (bank_end) col_o = col_inc;
    end
  end
endmodule

// File: rtl/dram_flat_addr.sv
module dram_flat_addr #(
  parameter int NUM_COLS = 101,
  parameter int BANK_W   = 3,
  parameter int COL_W    = 7,
  parameter int ADDR_W   = 9
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [ADDR_W-1:0] flat_o
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(NUM_COLS);

  assign flat_o = ADDR_W'(bank_i) * STRIDE + ADDR_W'(col_i);
endmodule

// File: rtl/dram_addr_seq.sv
module dram_addr_seq
  import dram_seq_pkg::*;
#(
  parameter  int NUM_BANKS = 5,
  parameter  int NUM_COLS  = 101,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int COL_W     = $clog2(NUM_COLS),
  localparam int ADDR_W    = $clog2(NUM_BANKS * NUM_COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_ld,
  input  logic              mode_in,
  input  logic              bank_ld,
  input  logic [BANK_W-1:0] bank_in,
  input  logic              col_ld,
  input  logic [COL_W-1:0]  col_in,
  input  logic              wr_stb,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col_o,
  output logic [ADDR_W-1:0] flat_o
);
  step_mode_e        mode_q;
  logic [BANK_W-1:0] bank_q, bank_ld_v, bank_step;
  logic [COL_W-1:0]  col_q, col_ld_v, col_step;
  logic              any_ld;

  dram_idx_clamp #(.W(BANK_W), .LIMIT(NUM_BANKS)) u_bank_clamp (
    .raw_i(bank_in), .idx_o(bank_ld_v)
  );
  dram_idx_clamp #(.W(COL_W), .LIMIT(NUM_COLS)) u_col_clamp (
    .raw_i(col_in), .idx_o(col_ld_v)
  );

  dram_step_next #(
    .NUM_BANKS(NUM_BANKS), .NUM_COLS(NUM_COLS), .BANK_W(BANK_W), .COL_W(COL_W)
  ) u_step (
    .mode_i(mode_q), .bank_i(bank_q), .col_i(col_q),
    .bank_o(bank_step), .col_o(col_step)
  );

  dram_flat_addr #(
    .NUM_COLS(NUM_COLS), .BANK_W(BANK_W), .COL_W(COL_W), .ADDR_W(ADDR_W)
  ) u_flat (
    .bank_i(bank_q), .col_i(col_q), .flat_o(flat_o)
  );

  assign any_ld = bank_ld | col_ld;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
      col_q  <= '0;
      mode_q <= STEP_COL;
    end else begin
      if (mode_ld) mode_q <= step_mode_e'(mode_in);
      if (any_ld) begin
        if (bank_ld) bank_q <= bank_ld_v;
        if (col_ld)  col_q  <= col_ld_v;
      end else if (wr_stb) begin
        bank_q <= bank_step;
        col_q  <= col_step;
      end
    end
  end

  assign bank_o = bank_q;
  assign col_o  = col_q;
endmodule

// File: rtl/dram_addr_seq_chk.sv
module dram_addr_seq_chk
  import dram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int NUM_COLS  = 101,
  parameter int BANK_W    = 3,
  parameter int COL_W     = 7,
  parameter int ADDR_W    = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              bank_ld,
  input logic              col_ld,
  input logic              wr_stb,
  input step_mode_e        mode_q,
  input logic [BANK_W-1:0] bank_o,
  input logic [COL_W-1:0]  col_o,
  input logic [ADDR_W-1:0] flat_o
);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);
  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(NUM_COLS - 1);
  localparam logic [ADDR_W-1:0] LAST_FLAT = ADDR_W'(NUM_BANKS * NUM_COLS - 1);
  localparam logic [BANK_W:0]   BANK_LIM  = (BANK_W+1)'(NUM_BANKS);
  localparam logic [COL_W:0]    COL_LIM   = (COL_W+1)'(NUM_COLS);

  logic step_only;
  assign step_only = wr_stb & ~bank_ld & ~col_ld;

  AST_RESET_ORIGIN: assert property (@(posedge clk) rst |=> (bank_o == '0 && col_o == '0)); // R1
  AST_BANK_RANGE: assert property (@(posedge clk) disable iff (rst) {1'b0, bank_o} < BANK_LIM); // R2
  AST_COL_RANGE: assert property (@(posedge clk) disable iff (rst) {1'b0, col_o} < COL_LIM); // R2
  AST_COL_FIRST_FLAT: assert property (@(posedge clk) disable iff (rst)
    (step_only && mode_q == STEP_COL) |=>
      flat_o == (($past(flat_o) == LAST_FLAT) ? '0 : $past(flat_o) + ADDR_W'(1))); // R4
  AST_BANK_FIRST_STEP: assert property (@(posedge clk) disable iff (rst)
    (step_only && mode_q == STEP_BANK && bank_o != LAST_BANK) |=>
      (bank_o == $past(bank_o) + BANK_W'(1) && $stable(col_o))); // R5
  AST_END_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step_only && bank_o == LAST_BANK && col_o == LAST_COL) |=> flat_o == '0); // R6
  AST_LOAD_BLOCKS_STEP: assert property (@(posedge clk) disable iff (rst)
    (col_ld && !bank_ld && wr_stb) |=> $stable(bank_o)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_stb && !bank_ld && !col_ld) |=> ($stable(bank_o) && $stable(col_o))); // R10
endmodule

bind dram_addr_seq dram_addr_seq_chk #(
  .NUM_BANKS(NUM_BANKS), .NUM_COLS(NUM_COLS),
  .BANK_W(BANK_W), .COL_W(COL_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst(rst), .bank_ld(bank_ld), .col_ld(col_ld), .wr_stb(wr_stb),
  .mode_q(mode_q), .bank_o(bank_o), .col_o(col_o), .flat_o(flat_o)
);

// File: tb/dram_addr_seq_tb_top.sv
`timescale 1ns/1ps
module dram_addr_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_ld = 1'b0, mode_in = 1'b0;
  logic       bank_ld = 1'b0, col_ld = 1'b0, wr_stb = 1'b0;
  logic [2:0] bank_in = '0;
  logic [6:0] col_in = '0;
  logic [2:0] bank_o;
  logic [6:0] col_o;
  logic [8:0] flat_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R1";

  int rb = 0, rc = 0, rm = 0;

  always #2 clk = ~clk;

  dram_addr_seq dut_i (
    .clk(clk), .rst(rst), .mode_ld(mode_ld), .mode_in(mode_in),
    .bank_ld(bank_ld), .bank_in(bank_in), .col_ld(col_ld), .col_in(col_in),
    .wr_stb(wr_stb), .bank_o(bank_o), .col_o(col_o), .flat_o(flat_o)
  );

  // Behavioural reference: steps an integer pointer
  always @(posedge clk) begin
    int f;
    if (rst) begin
      rb = 0; rc = 0; rm = 0;
    end else begin
      if (bank_ld || col_ld) begin
        if (bank_ld) rb = (int'(bank_in) <= 4) ? int'(bank_in) : 0;
        if (col_ld)  rc = (int'(col_in) <= 100) ? int'(col_in) : 0;
      end else if (wr_stb) begin
        if (rm == 0) begin
          f = (rb * 101 + rc + 1) % 505;
          rb = f / 101; rc = f % 101;
        end else if (rb < 4) rb = rb + 1;
        else begin rb = 0; rc = (rc + 1) % 101; end
      end
      if (mode_ld) rm = int'(mode_in);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk({tag, " bank vs model"}, int'(bank_o), rb);
    chk({tag, " col vs model"}, int'(col_o), rc);
    chk({tag, " R3 flat vs model"}, int'(flat_o), rb * 101 + rc);
  endtask

  task automatic cyc(input bit ml, input bit mv, input bit bl, input int bv,
                     input bit cl, input int cv, input bit ws);
    mode_ld = ml; mode_in = mv; bank_ld = bl; bank_in = 3'(bv);
    col_ld = cl; col_in = 7'(cv); wr_stb = ws;
    @(negedge clk);
    cmp_model();
  endtask

  task automatic expect_at(input string req, input int b, input int c);
    chk({req, " bank"}, int'(bank_o), b);
    chk({req, " col"}, int'(col_o), c);
    chk({req, " flat"}, int'(flat_o), b * 101 + c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    expect_at("R1 reset origin", 0, 0);
    rst = 1'b0;
    cyc(0,0, 0,0, 0,0, 1);
    expect_at("R1 default column-first", 0, 1);

    tag = "R4";
    cyc(0,0, 1,0, 1,99, 0);  expect_at("R7 load visible", 0, 99);
    cyc(0,0, 0,0, 0,0, 1);   expect_at("R4 col step", 0, 100);
    cyc(0,0, 0,0, 0,0, 1);   expect_at("R4 next bank", 1, 0);
    cyc(0,0, 0,0, 0,0, 1);   expect_at("R4 flat 102", 1, 1);

    tag = "R5";
    cyc(1,1, 1,3, 1,7, 0);   expect_at("R5 load", 3, 7);
    cyc(0,0, 0,0, 0,0, 1);   expect_at("R5 bank step", 4, 7);
    cyc(0,0, 0,0, 0,0, 1);   expect_at("R5 next column", 0, 8);

    tag = "R6";
    cyc(0,0, 1,4, 1,100, 0);
    cyc(0,0, 0,0, 0,0, 1);   expect_at("R6 wrap bank-first", 0, 0);
    cyc(1,0, 1,4, 1,100, 0);
    cyc(0,0, 0,0, 0,0, 1);   expect_at("R6 wrap column-first", 0, 0);

    tag = "R7";
    cyc(0,0, 0,0, 1,50, 1);  expect_at("R7 col load beats strobe", 0, 50);
    cyc(0,0, 1,2, 0,0, 1);   expect_at("R7 bank load beats strobe", 2, 50);

    tag = "R8";
    cyc(0,0, 1,6, 1,120, 0); expect_at("R8 clamp to zero", 0, 0);
    cyc(0,0, 1,4, 1,100, 0); expect_at("R8 limits kept", 4, 100);
    chk("R3 top flat", int'(flat_o), 504);

    tag = "R9";
    cyc(0,0, 1,0, 1,5, 0);
    cyc(1,1, 0,0, 0,0, 1);   expect_at("R9 strobe uses old mode", 0, 6);
    cyc(0,0, 0,0, 0,0, 1);   expect_at("R9 new mode active", 1, 6);

    tag = "R10";
    for (int i = 0; i < 3; i++) begin
      cyc(0,0, 0,0, 0,0, 0); expect_at("R10 idle hold", 1, 6);
    end

    tag = "R3";
    for (int i = 0; i < 4000; i++) begin
      cyc($urandom_range(0, 15) == 0, 1'($urandom_range(0, 1)),
          $urandom_range(0, 40) == 0, int'($urandom_range(0, 7)),
          $urandom_range(0, 40) == 0, int'($urandom_range(0, 127)),
          $urandom_range(0, 3) != 0);
      checks++;
      if (int'(bank_o) > 4 || int'(col_o) > 100) begin
        errors++;
        $display("FAIL R2 range actual=%0d,%0d expected<=4,100", bank_o, col_o);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule